// File: doc/BRIEF.md
# Descriptor-Chain DMA Front End

This block feeds a crypto datapath from memory. Software builds a chain of eight-word descriptors in memory. It writes the address of the first descriptor to `list_addr` and pulses `cmd_start`. The engine fetches each descriptor one word at a time over a 32-bit read port with a valid/ready request and a response strobe. It then reads the item's source words and presents each one to the core together with the item's sideband flags. If the item names a destination buffer, the engine writes the core result back through a write port.

Each item's control word decides what happens when the item completes. The chain can stop there, or it can halt until `cmd_restart` is pulsed, or it can follow the next pointer. The control word also picks which completion status bits the item raises. A chain can carry an associated-data item first, with a payload item after it. A pause lets software rewrite the descriptor that the engine will fetch next. The core is a stub that either passes data through or inverts it, chosen by a parameter.

Status bits stay set until software writes ones to `int_clr`. Three debug outputs show the current descriptor, source and destination pointers.

Top module: `llist_dma`

## Requirements
- R1: After reset, `int_status` is zero, `busy` and `paused` are low, and no read or write request is asserted.
- R2: On `cmd_start` in idle, the engine reads eight words at ascending word addresses from `list_addr`. In fetch order they are: source address, source length (bytes), destination address, destination length (bytes), sideband, an ignored word, control, next pointer. Every request address is word aligned.
- R3: The engine reads the item's source words in ascending address order. Each returned word appears for one cycle on `core_data` with `core_valid` high. `core_flags` carries sideband bits [7:0]: bit0 string start, bit1 string last, bit2 cipher start, bit3 associated data, and bits [7:4] the key channel.
- R4: After each of the first (destination length / 4) core words, the engine writes the core result to the next ascending destination address. A destination length of zero produces no writes.
- R5: Control bit0 (last) ends the chain after the item and returns the engine to idle. Otherwise the engine fetches the descriptor at the next pointer.
- R6: Control bit1 (pause) parks the engine after the item with `paused` high and no bus requests. On `cmd_restart` it fetches the descriptor at the next pointer, reading that memory again.
- R7: When an item with non-zero source length ends, control bit2 sets `int_status[0]` (source done), bit3 sets `int_status[1]` (destination done) and bit4 sets `int_status[2]` (list done).
- R8: An item whose source length is below four bytes issues no data reads. It sets `int_status[3]` instead of its report bits.
- R9: Status bits are sticky. A one on `int_clr[i]` clears bit i, and a bit that is set in the same cycle stays set.
- R10: A read response with `rd_rerr`, or a descriptor pointer whose low three bits are not zero, sets `int_status[4]` and returns the engine to idle.
- R11: `cur_desc_addr` shows the address of the current descriptor. `cur_src_addr` and `cur_dst_addr` show the next source and destination word addresses.
- R12: `cmd_start` is ignored unless the engine is idle. `cmd_restart` is ignored unless it is paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start a chain at `list_addr` |
| cmd_restart | input | 1 | Resume a paused chain |
| list_addr | input | AW | First descriptor address |
| int_clr | input | 5 | Write-one-to-clear for status bits |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read request address |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 32 | Read response data |
| rd_rerr | input | 1 | Read response error |
| wr_valid | output | 1 | Destination write valid |
| wr_addr | output | AW | Destination write address |
| wr_data | output | 32 | Destination write data |
| wr_ready | input | 1 | Destination write accepted |
| core_valid | output | 1 | Word presented to core |
| core_data | output | 32 | Word presented to core |
| core_flags | output | 8 | Item sideband for the core |
| busy | output | 1 | Chain in progress (including paused) |
| paused | output | 1 | Waiting for restart |
| int_status | output | 5 | Sticky completion and error status |
| cur_desc_addr | output | AW | Current descriptor address |
| cur_src_addr | output | AW | Next source word address |
| cur_dst_addr | output | AW | Next destination word address |

## Verification
The bench runs a two-item chain in which the associated-data item has no destination and the payload item has fewer destination words than source words. An engine that writes for every source word would produce extra writes, and one that skipped the link would lose the payload. A paused chain has its next descriptor rewritten before restart, and a stray start is pulsed while it is paused. A stale prefetch or a start that is not ignored would stream the wrong data or reload the chain. The bench also covers a zero-length item, a failing data read and a misaligned next pointer, because a wrong design would report the item as done, stream data, or keep running after the error. A write-one-to-clear that touches one bit checks that the other status bits are not disturbed.

// File: rtl/llist_dma_pkg.sv
package llist_dma_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_DREQ, S_DRSP, S_ITEM, S_SREQ, S_SRSP, S_WR, S_END, S_PAUSE
   } dma_state_e;

   localparam int STS_W     = 5;
   localparam int STS_SRC   = 0;
   localparam int STS_DST   = 1;
   localparam int STS_LIST  = 2;
   localparam int STS_ZERO  = 3;
   localparam int STS_ERR   = 4;

   localparam int CTL_W        = 5;
   localparam int CTL_LAST     = 0;
   localparam int CTL_PAUSE    = 1;
   localparam int CTL_REP_SRC  = 2;
   localparam int CTL_REP_DST  = 3;
   localparam int CTL_REP_LIST = 4;

   localparam int DESC_WORDS = 8;
   localparam int SIDE_W     = 8;
endpackage

// File: rtl/llist_dma_irq.sv
module llist_dma_irq #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] status_o
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) status_o[i] <= 1'b0;
            else        status_o[i] <= set_i[i] | (status_o[i] & ~clr_i[i]);
         end
      end
   endgenerate
endmodule

// File: rtl/llist_dma_core_stub.sv
module llist_dma_core_stub #(
   parameter int DW     = 32,
   parameter bit INVERT = 1'b0
) (
   input  logic [DW-1:0] in_data,
   output logic [DW-1:0] out_data
);
   generate
      if (INVERT) begin : g_inv
         assign out_data = ~in_data;
      end else begin : g_pass
         assign out_data = in_data;
      end
   endgenerate
endmodule

// File: rtl/llist_dma.sv
module llist_dma
   import llist_dma_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LW          = 32,
   parameter bit CORE_INVERT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_restart,
   input  logic [AW-1:0]     list_addr,
   input  logic [STS_W-1:0]  int_clr,
   output logic              rd_valid,
   output logic [AW-1:0]     rd_addr,
   input  logic              rd_ready,
   input  logic              rd_rvalid,
   input  logic [31:0]       rd_rdata,
   input  logic              rd_rerr,
   output logic              wr_valid,
   output logic [AW-1:0]     wr_addr,
   output logic [31:0]       wr_data,
   input  logic              wr_ready,
   output logic              core_valid,
   output logic [31:0]       core_data,
   output logic [SIDE_W-1:0] core_flags,
   output logic              busy,
   output logic              paused,
   output logic [STS_W-1:0]  int_status,
   output logic [AW-1:0]     cur_desc_addr,
   output logic [AW-1:0]     cur_src_addr,
   output logic [AW-1:0]     cur_dst_addr
);
   localparam int CW  = LW - 2;
   localparam int IXW = $clog2(DESC_WORDS);

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("llist_dma: AW must lie in 8..32");
      end
      if (LW < 4 || LW > 32) begin : g_bad_lw
         $error("llist_dma: LW must lie in 4..32");
      end
   endgenerate

   dma_state_e        state;
   logic [IXW-1:0]    idx;
   logic [AW-1:0]     desc_ptr, src_ptr, dst_ptr;
   logic [AW-1:0]     d_src, d_dst, d_next;
   logic [CW-1:0]     d_swords, d_dwords, src_left, dst_left;
   logic [SIDE_W-1:0] d_side;
   logic [CTL_W-1:0]  d_ctrl;
   logic              zero_item;
   logic              next_bad, go_next, rsp_err;
   logic [STS_W-1:0]  sts_set;
   logic [31:0]       core_out;

   assign next_bad = (d_next[2:0] != 3'b000);
   assign go_next  = (state == S_END && !d_ctrl[CTL_LAST] && !d_ctrl[CTL_PAUSE]) ||
                     (state == S_PAUSE && cmd_restart);
   assign rsp_err  = (state == S_DRSP || state == S_SRSP) && rd_rvalid && rd_rerr;

   always_comb begin
      sts_set = '0;
      if (state == S_END) begin
         if (zero_item) sts_set[STS_ZERO] = 1'b1;
         else begin
            sts_set[STS_SRC]  = d_ctrl[CTL_REP_SRC];
            sts_set[STS_DST]  = d_ctrl[CTL_REP_DST];
            sts_set[STS_LIST] = d_ctrl[CTL_REP_LIST];
         end
      end
      sts_set[STS_ERR] = rsp_err || (go_next && next_bad) ||
                         (state == S_IDLE && cmd_start && list_addr[2:0] != 3'b000);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         idx        <= '0;
         desc_ptr   <= '0;
         src_ptr    <= '0;
         dst_ptr    <= '0;
         d_src      <= '0;
         d_dst      <= '0;
         d_next     <= '0;
         d_swords   <= '0;
         d_dwords   <= '0;
         d_side     <= '0;
         d_ctrl     <= '0;
         src_left   <= '0;
         dst_left   <= '0;
         zero_item  <= 1'b0;
         core_valid <= 1'b0;
         core_data  <= '0;
      end else begin
         core_valid <= 1'b0;
         unique case (state)
            S_IDLE: if (cmd_start) begin
               desc_ptr <= list_addr;
               idx      <= '0;
               state    <= (list_addr[2:0] != 3'b000) ? S_IDLE : S_DREQ;
            end
            S_DREQ: if (rd_ready) state <= S_DRSP;
            S_DRSP: if (rd_rvalid) begin
               if (rd_rerr) state <= S_IDLE;
               else begin
                  case (idx)
                     3'd0: d_src    <= rd_rdata[AW-1:0];
                     3'd1: d_swords <= rd_rdata[LW-1:2];
                     3'd2: d_dst    <= rd_rdata[AW-1:0];
                     3'd3: d_dwords <= rd_rdata[LW-1:2];
                     3'd4: d_side   <= rd_rdata[SIDE_W-1:0];
                     3'd6: d_ctrl   <= rd_rdata[CTL_W-1:0];
                     3'd7: d_next   <= rd_rdata[AW-1:0];
                     default: ;
                  endcase
                  idx   <= idx + 1'b1;
                  state <= (idx == IXW'(DESC_WORDS - 1)) ? S_ITEM : S_DREQ;
               end
            end
            S_ITEM: begin
               src_ptr   <= d_src;
               dst_ptr   <= d_dst;
               src_left  <= d_swords;
               dst_left  <= d_dwords;
               zero_item <= (d_swords == '0);
               state     <= (d_swords == '0) ? S_END : S_SREQ;
            end
            S_SREQ: if (rd_ready) state <= S_SRSP;
            S_SRSP: if (rd_rvalid) begin
               if (rd_rerr) state <= S_IDLE;
               else begin
                  core_valid <= 1'b1;
                  core_data  <= rd_rdata;
                  src_ptr    <= src_ptr + AW'(4);
                  src_left   <= src_left - 1'b1;
                  if (dst_left != '0)      state <= S_WR;
                  else if (src_left == 1) state <= S_END;
                  else                    state <= S_SREQ;
               end
            end
            S_WR: if (wr_ready) begin
               dst_ptr  <= dst_ptr + AW'(4);
               dst_left <= dst_left - 1'b1;
               state    <= (src_left == '0) ? S_END : S_SREQ;
            end
            S_END: begin
               if (d_ctrl[CTL_LAST])       state <= S_IDLE;
               else if (d_ctrl[CTL_PAUSE]) state <= S_PAUSE;
               else if (next_bad)          state <= S_IDLE;
               else begin
                  desc_ptr <= d_next;
                  idx      <= '0;
                  state    <= S_DREQ;
               end
            end
            S_PAUSE: if (cmd_restart) begin
               if (next_bad) state <= S_IDLE;
               else begin
                  desc_ptr <= d_next;
                  idx      <= '0;
                  state    <= S_DREQ;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   llist_dma_core_stub #(.DW(32), .INVERT(CORE_INVERT)) u_core (
      .in_data (core_data),
      .out_data(core_out)
   );

   llist_dma_irq #(.W(STS_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (sts_set),
      .clr_i   (int_clr),
      .status_o(int_status)
   );

   assign rd_valid      = (state == S_DREQ) || (state == S_SREQ);
   assign rd_addr       = (state == S_DREQ) ? desc_ptr + (AW'(idx) << 2) : src_ptr;
   assign wr_valid      = (state == S_WR);
   assign wr_addr       = dst_ptr;
   assign wr_data       = core_out;
   assign core_flags    = d_side;
   assign busy          = (state != S_IDLE);
   assign paused        = (state == S_PAUSE);
   assign cur_desc_addr = desc_ptr;
   assign cur_src_addr  = src_ptr;
   assign cur_dst_addr  = dst_ptr;
endmodule

// File: rtl/llist_dma_chk.sv
module llist_dma_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_valid,
   input logic [AW-1:0] rd_addr,
   input logic          rd_ready,
   input logic          wr_valid,
   input logic [AW-1:0] wr_addr,
   input logic [31:0]   wr_data,
   input logic          wr_ready,
   input logic          busy,
   input logic          paused,
   input logic [4:0]    int_status,
   input logic [4:0]    int_clr
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid || wr_valid) |-> busy);

   p_rd_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_addr[1:0] == 2'b00));

   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

   p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   p_pause_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> (!rd_valid && !wr_valid && busy));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_status & ~int_clr) != 5'b0 |=> ((($past(int_status) & ~$past(int_clr)) & ~int_status) == 5'b0));

   p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_status[4]) |-> !busy);
endmodule

bind llist_dma llist_dma_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
   .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .wr_ready(wr_ready), .busy(busy), .paused(paused),
   .int_status(int_status), .int_clr(int_clr)
);

// File: tb/llist_dma_tb_top.sv
module llist_dma_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0, cmd_restart = 1'b0;
   logic [31:0] list_addr = '0;
   logic [4:0]  int_clr = '0;
   logic        rd_valid, rd_rvalid = 1'b0, rd_rerr = 1'b0;
   logic        rd_ready;
   logic [31:0] rd_addr, rd_rdata = '0;
   logic        wr_valid, wr_ready = 1'b0;
   logic [31:0] wr_addr, wr_data;
   logic        core_valid;
   logic [31:0] core_data;
   logic [7:0]  core_flags;
   logic        busy, paused;
   logic [4:0]  int_status;
   logic [31:0] cur_desc_addr, cur_src_addr, cur_dst_addr;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [31:0] mem [0:255];
   logic [39:0] exp_core [$];
   logic [63:0] exp_wr [$];

   assign rd_ready = 1'b1;
   always #10 clk = ~clk;

   llist_dma dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_restart(cmd_restart),
      .list_addr(list_addr), .int_clr(int_clr), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .rd_rerr(rd_rerr),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .core_valid(core_valid), .core_data(core_data), .core_flags(core_flags),
      .busy(busy), .paused(paused), .int_status(int_status),
      .cur_desc_addr(cur_desc_addr), .cur_src_addr(cur_src_addr), .cur_dst_addr(cur_dst_addr)
   );

   // memory model: reads answered one cycle after acceptance, 0x400 and above faults
   always @(posedge clk) begin
      rd_rvalid <= rd_valid && rd_ready;
      rd_rdata  <= mem[rd_addr[9:2]];
      rd_rerr   <= rd_valid && (rd_addr >= 32'h400);
      wr_ready  <= rst_n ? ~wr_ready : 1'b0;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && core_valid) begin
         if (exp_core.size() == 0) check(1'b0, "R3 unexpected core word", {24'h0, core_flags, core_data}, 64'h0);
         else begin
            logic [39:0] e;
            e = exp_core.pop_front();
            check({core_flags, core_data} == e, "R3 core word", {24'h0, core_flags, core_data}, {24'h0, e});
         end
      end
      if (rst_n && wr_valid && wr_ready) begin
         if (exp_wr.size() == 0) check(1'b0, "R4 unexpected write", {wr_addr, wr_data}, 64'h0);
         else begin
            logic [63:0] e;
            e = exp_wr.pop_front();
            check({wr_addr, wr_data} == e, "R4 write", {wr_addr, wr_data}, e);
         end
      end
   end

   task automatic put_desc(input logic [31:0] at, input logic [31:0] src, input logic [31:0] slen,
                           input logic [31:0] dst, input logic [31:0] dlen, input logic [31:0] side,
                           input logic [31:0] ctrl, input logic [31:0] nxt);
      mem[at[9:2]+0] = src;  mem[at[9:2]+1] = slen; mem[at[9:2]+2] = dst;
      mem[at[9:2]+3] = dlen; mem[at[9:2]+4] = side; mem[at[9:2]+5] = 32'hDEADBEEF;
      mem[at[9:2]+6] = ctrl; mem[at[9:2]+7] = nxt;
   endtask

   task automatic push_core(input logic [31:0] src, input int n, input logic [7:0] fl);
      for (int i = 0; i < n; i++) exp_core.push_back({fl, mem[src[9:2]+i]});
   endtask

   task automatic push_wr(input logic [31:0] dst, input logic [31:0] src, input int n);
      for (int i = 0; i < n; i++) exp_wr.push_back({dst + 32'(4*i), mem[src[9:2]+i]});
   endtask

   task automatic pulse_start(input logic [31:0] a);
      @(negedge clk); list_addr = a; cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
   endtask

   task automatic pulse_restart();
      @(negedge clk); cmd_restart = 1'b1;
      @(negedge clk); cmd_restart = 1'b0;
   endtask

   task automatic clear(input logic [4:0] v);
      @(negedge clk); int_clr = v;
      @(negedge clk); int_clr = '0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 + 32'(i * 32'h00010003);
      repeat (3) @(negedge clk);
      check(int_status == 5'b0 && !busy && !paused && !rd_valid && !wr_valid, "R1 reset",
            {59'h0, int_status}, 64'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single item, report source and destination done
      put_desc(32'h000, 32'h100, 16, 32'h800, 16, 32'h35, 32'h0D, 32'h0);
      push_core(32'h100, 4, 8'h35);
      push_wr(32'h800, 32'h100, 4);
      pulse_start(32'h000);
      wait_idle();
      check(int_status == 5'b00011, "R7 src+dst done", {59'h0, int_status}, 64'h3);
      check(exp_core.size() == 0 && exp_wr.size() == 0, "R2 all items seen",
            64'(exp_core.size()), 64'h0);
      check(cur_desc_addr == 32'h000, "R11 desc addr", 64'(cur_desc_addr), 64'h0);
      check(cur_src_addr == 32'h110, "R11 src addr", 64'(cur_src_addr), 64'h110);
      check(cur_dst_addr == 32'h810, "R11 dst addr", 64'(cur_dst_addr), 64'h810);
      clear(5'b00001);
      check(int_status == 5'b00010, "R9 clear one bit", {59'h0, int_status}, 64'h2);
      clear(5'b11111);
      check(int_status == 5'b0, "R9 clear all", {59'h0, int_status}, 64'h0);

      // two-item chain: associated data then payload with short destination
      put_desc(32'h020, 32'h140, 8, 32'h0, 0, 32'h09, 32'h00, 32'h040);
      put_desc(32'h040, 32'h150, 12, 32'h900, 8, 32'h36, 32'h11, 32'h0);
      push_core(32'h140, 2, 8'h09);
      push_core(32'h150, 3, 8'h36);
      push_wr(32'h900, 32'h150, 2);
      pulse_start(32'h020);
      wait_idle();
      check(int_status == 5'b00100, "R5 chain list done", {59'h0, int_status}, 64'h4);
      check(exp_core.size() == 0 && exp_wr.size() == 0, "R5 both items streamed",
            64'(exp_core.size() + exp_wr.size()), 64'h0);
      check(cur_desc_addr == 32'h040, "R11 followed link", 64'(cur_desc_addr), 64'h40);
      clear(5'b11111);

      // pause, then rewrite next descriptor before restart
      put_desc(32'h060, 32'h160, 8, 32'h0, 0, 32'h00, 32'h06, 32'h080);
      put_desc(32'h080, 32'h100, 4, 32'h0, 0, 32'h00, 32'h01, 32'h0);
      push_core(32'h160, 2, 8'h00);
      pulse_start(32'h060);
      while (!paused) @(negedge clk);
      repeat (3) @(negedge clk);
      check(paused && busy, "R6 parked", {62'h0, paused, busy}, 64'h3);
      check(int_status == 5'b00001, "R6 item done before pause", {59'h0, int_status}, 64'h1);
      pulse_start(32'h000);
      check(paused && cur_desc_addr == 32'h060, "R12 start ignored while paused",
            64'(cur_desc_addr), 64'h60);
      put_desc(32'h080, 32'h170, 4, 32'hA00, 4, 32'h0F, 32'h09, 32'h0);
      push_core(32'h170, 1, 8'h0F);
      push_wr(32'hA00, 32'h170, 1);
      pulse_restart();
      wait_idle();
      check(int_status == 5'b00011, "R6 resumed with rewritten item", {59'h0, int_status}, 64'h3);
      check(exp_core.size() == 0 && exp_wr.size() == 0, "R6 resumed data",
            64'(exp_core.size() + exp_wr.size()), 64'h0);
      clear(5'b11111);

      // restart in idle ignored
      pulse_restart();
      @(negedge clk);
      check(!busy, "R12 restart ignored when idle", {63'h0, busy}, 64'h0);

      // zero-length item
      put_desc(32'h0A0, 32'h100, 0, 32'hB00, 8, 32'h00, 32'h0D, 32'h0);
      pulse_start(32'h0A0);
      wait_idle();
      check(int_status == 5'b01000, "R8 zero length status", {59'h0, int_status}, 64'h8);
      clear(5'b11111);

      // data read fault
      put_desc(32'h0C0, 32'h500, 8, 32'h0, 0, 32'h00, 32'h05, 32'h0);
      pulse_start(32'h0C0);
      wait_idle();
      check(int_status == 5'b10000 && !busy, "R10 read fault", {59'h0, int_status}, 64'h10);
      clear(5'b11111);

      // misaligned next pointer
      put_desc(32'h0E0, 32'h100, 4, 32'h0, 0, 32'h00, 32'h00, 32'h104);
      push_core(32'h100, 1, 8'h00);
      pulse_start(32'h0E0);
      wait_idle();
      check(int_status == 5'b10000 && !busy, "R10 misaligned link", {59'h0, int_status}, 64'h10);
      check(exp_core.size() == 0, "R10 item before bad link", 64'(exp_core.size()), 64'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule